// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every data beat of a synchronous DRAM burst. A controller raises a one-cycle go pulse together with a start column and a 4-bit mode image. The mode image holds the burst length code and the ordering bit. From the next clock on, the block presents one column per cycle with a valid strobe. It raises a last flag on the final beat of a fixed-length burst.

Full-page bursts walk the whole 512-column row, wrap at the row end and continue until a stop request arrives. A stop request ends any burst in progress. A new go pulse restarts the walk from a fresh column on any clock, so column commands can be issued back to back. CAS latency, row and bank handling and data paths belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after its release, with no go pulse, `col_vld` and `col_last` are low.
- R2: A go pulse sampled on a rising edge makes `col_vld` high from that edge, with `col_out` equal to the sampled `go_col` (beat 0).
- R3: With `mode_img[3]`=0 (sequential) and length N of 2, 4 or 8, beat k carries the low log2(N) bits of (start + k) modulo N, and the upper column bits stay those of the start column. `mode_img[2:0]` codes are 0=1, 1=2, 2=4, 3=8, 7=full page.
- R4: With `mode_img[3]`=1 (interleaved) and length N of 2, 4 or 8, beat k carries the start column XOR k on the low log2(N) bits, and the upper bits are unchanged.
- R5: A fixed burst of length N shows exactly N valid beats, with `col_last` high only on the Nth beat. `col_vld` is low on the cycle after it.
- R6: Length code 0 gives a single beat with `col_last` high in that same cycle.
- R7: Length code 7 increments the column by one per beat, wraps from 511 to 0, never raises `col_last`, and runs until stopped.
- R8: `burst_stop` sampled high during a burst makes `col_vld` low on the next cycle. Sampled while idle, it has no effect, and a later burst runs normally.
- R9: A go pulse during a burst discards the old burst and starts the new column and mode on the next cycle. It wins over a `burst_stop` sampled on the same edge.
- R10: Reserved length codes 4, 5 and 6 behave as length 1.
- R11: In full-page mode the ordering bit is ignored and the walk is sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_go | input | 1 | Start or restart a burst this cycle |
| go_col | input | 9 | Start column sampled with `burst_go` |
| mode_img | input | 4 | [2:0] length code, [3] ordering (1 = interleaved) |
| burst_stop | input | 1 | Truncate the running burst |
| col_out | output | 9 | Column address of the current beat |
| col_vld | output | 1 | A beat is present on `col_out` |
| col_last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench aims at start columns that sit mid-block, so a generator that carried into the upper bits instead of wrapping inside the aligned block would print columns outside the block. It also pairs sequential and interleaved runs from the same column, where a wrong XOR or add would reorder the beats. A full-page run crosses column 511, so a design that stopped or flagged last at the row end would drop valid there. Restarts during a burst, a stop on the same edge as a go, stops while idle and reserved length codes are checked for a stale beat, a lost burst or a spurious beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   localparam int MODE_W = 4;
   localparam int LEN_W  = 3;
   localparam logic [LEN_W-1:0] LEN_ONE   = 3'd0;
   localparam logic [LEN_W-1:0] LEN_TWO   = 3'd1;
   localparam logic [LEN_W-1:0] LEN_FOUR  = 3'd2;
   localparam logic [LEN_W-1:0] LEN_EIGHT = 3'd3;
   localparam logic [LEN_W-1:0] LEN_PAGE  = 3'd7;
   localparam int ORDER_BIT = 3;

   typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [LEN_W-1:0] len_code,
   output logic [COL_W-1:0] wrap_mask,
   output logic             page_mode
);
   localparam logic [COL_W-1:0] MASK_2 = COL_W'(1);
   localparam logic [COL_W-1:0] MASK_4 = COL_W'(3);
   localparam logic [COL_W-1:0] MASK_8 = COL_W'(7);

   always_comb begin
      page_mode = 1'b0;
      unique case (len_code)
         LEN_TWO:   wrap_mask = MASK_2;
         LEN_FOUR:  wrap_mask = MASK_4;
         LEN_EIGHT: wrap_mask = MASK_8;
         LEN_PAGE: begin
            wrap_mask = '1;
            page_mode = 1'b1;
         end
         default:   wrap_mask = '0;
      endcase
   end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             stop,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             page_mode,
   output logic             busy,
   output logic [COL_W-1:0] beat,
   output logic             final_beat
);
   assign final_beat = busy & ~page_mode & (beat == wrap_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         beat <= '0;
      end else if (go) begin
         busy <= 1'b1;
         beat <= '0;
      end else if (busy && (stop || final_beat)) begin
         busy <= 1'b0;
         beat <= '0;
      end else if (busy) begin
         beat <= beat + 1'b1;
      end
   end

   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !final_beat && !stop && !go |=> busy && beat == $past(beat) + 1'b1); // R5
   AST_END_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      final_beat && !go |=> !busy); // R5
   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && stop && !go |=> !busy); // R8
endmodule

// File: rtl/bcg_addr_order.sv
module bcg_addr_order #(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             use_xor,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] seq_sum;
   assign seq_sum = base_col + beat;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
         if (!wrap_mask[b])
            col[b] = base_col[b];
         else if (use_xor)
            col[b] = base_col[b] ^ beat[b];
         else
            col[b] = seq_sum[b];
      end
   end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             burst_go,
   input  logic [COL_W-1:0] go_col,
   input  logic [3:0]       mode_img,
   input  logic             burst_stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_vld,
   output logic             col_last
);
   if (COL_W < 4) begin : g_bad_width
      $error("burst_col_gen: COL_W must be at least 4");
   end

   logic [COL_W-1:0] mask_d, mask_q, base_q, beat;
   logic             page_d, page_q;
   order_e           order_q;

   bcg_len_decode #(.COL_W(COL_W)) len_i (
      .len_code  (mode_img[LEN_W-1:0]),
      .wrap_mask (mask_d),
      .page_mode (page_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         page_q  <= 1'b0;
         order_q <= ORD_SEQ;
      end else if (burst_go) begin
         base_q  <= go_col;
         mask_q  <= mask_d;
         page_q  <= page_d;
         order_q <= (mode_img[ORDER_BIT] && !page_d) ? ORD_XOR : ORD_SEQ;
      end
   end

   bcg_beat_ctr #(.COL_W(COL_W)) ctr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (burst_go),
      .stop       (burst_stop),
      .wrap_mask  (mask_q),
      .page_mode  (page_q),
      .busy       (col_vld),
      .beat       (beat),
      .final_beat (col_last)
   );

   bcg_addr_order #(.COL_W(COL_W)) ord_i (
      .base_col  (base_q),
      .beat      (beat),
      .wrap_mask (mask_q),
      .use_xor   (order_q == ORD_XOR),
      .col       (col_out)
   );

   AST_GO_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
      burst_go |=> col_vld && col_out == $past(go_col)); // R2
   AST_LAST_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_vld); // R5
   AST_IDLE_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !col_vld && !burst_go |=> !col_vld); // R8
   AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld && !page_q && !burst_go |=> !col_vld || ((col_out & ~mask_q) == ($past(col_out) & ~mask_q))); // R3
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       burst_go = 1'b0;
   logic [8:0] go_col = '0;
   logic [3:0] mode_img = '0;
   logic       burst_stop = 1'b0;
   logic [8:0] col_out;
   logic       col_vld, col_last;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_col_gen dut_i (.*);

   localparam int NV = 9;
   localparam logic [3:0] V_MODE [NV] = '{4'h2, 4'hA, 4'h3, 4'hB, 4'h1, 4'h9, 4'h0, 4'h5, 4'h8};
   localparam logic [8:0] V_COL  [NV] = '{9'h0F5, 9'h0F5, 9'h1AD, 9'h1AD, 9'h033, 9'h032, 9'h155, 9'h0AA, 9'h1FF};
   localparam int         V_N    [NV] = '{4, 4, 8, 8, 2, 2, 1, 1, 1};
   localparam logic [8:0] V_EXP  [NV][8] = '{
      '{9'h0F5, 9'h0F6, 9'h0F7, 9'h0F4, 0, 0, 0, 0},
      '{9'h0F5, 9'h0F4, 9'h0F7, 9'h0F6, 0, 0, 0, 0},
      '{9'h1AD, 9'h1AE, 9'h1AF, 9'h1A8, 9'h1A9, 9'h1AA, 9'h1AB, 9'h1AC},
      '{9'h1AD, 9'h1AC, 9'h1AF, 9'h1AE, 9'h1A9, 9'h1A8, 9'h1AB, 9'h1AA},
      '{9'h033, 9'h032, 0, 0, 0, 0, 0, 0},
      '{9'h032, 9'h033, 0, 0, 0, 0, 0, 0},
      '{9'h155, 0, 0, 0, 0, 0, 0, 0},
      '{9'h0AA, 0, 0, 0, 0, 0, 0, 0},
      '{9'h1FF, 0, 0, 0, 0, 0, 0, 0}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] m);
      if (m[2:0] inside {3'd4, 3'd5, 3'd6}) return "R10 reserved length";
      if (m[2:0] == 3'd0) return "R6 single beat";
      if (m[3]) return "R4 interleaved";
      return "R3 sequential";
   endfunction

   task automatic go(input logic [3:0] m, input logic [8:0] c);
      @(negedge clk);
      burst_go = 1'b1; mode_img = m; go_col = c;
      @(negedge clk);
      burst_go = 1'b0;
   endtask

   task automatic beat_chk(input string tag, input logic [8:0] c, input logic l);
      chk({tag, " vld"}, 32'(col_vld), 32'd1);
      chk({tag, " col"}, 32'(col_out), 32'(c));
      chk({tag, " last"}, 32'(col_last), 32'(l));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 vld in reset", 32'(col_vld), 0);
      chk("R1 last in reset", 32'(col_last), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 vld after reset", 32'(col_vld), 0);

      // vector table: R2 beat 0, R3/R4 ordering, R5 count, R6, R10
      for (int v = 0; v < NV; v++) begin
         go(V_MODE[v], V_COL[v]);
         for (int k = 0; k < V_N[v]; k++) begin
            if (k > 0) @(negedge clk);
            beat_chk(k == 0 ? "R2 beat0" : tag_of(V_MODE[v]), V_EXP[v][k], k == V_N[v] - 1);
            if (k == 0) chk(tag_of(V_MODE[v]), 32'(col_out), 32'(V_EXP[v][0]));
         end
         @(negedge clk);
         chk("R5 vld low after burst", 32'(col_vld), 0);
      end

      // R7 full page wraps 511 -> 0, then R8 stop
      go(4'h7, 9'h1FE);
      beat_chk("R7 page", 9'h1FE, 0);
      @(negedge clk); beat_chk("R7 page", 9'h1FF, 0);
      @(negedge clk); beat_chk("R7 page wrap", 9'h000, 0);
      @(negedge clk); beat_chk("R7 page", 9'h001, 0);
      burst_stop = 1'b1;
      @(negedge clk);
      burst_stop = 1'b0;
      chk("R8 stop page", 32'(col_vld), 0);

      // R11 ordering bit ignored in full page
      go(4'hF, 9'h0FD);
      beat_chk("R11 page seq", 9'h0FD, 0);
      @(negedge clk); beat_chk("R11 page seq", 9'h0FE, 0);
      @(negedge clk); beat_chk("R11 page seq", 9'h0FF, 0);
      @(negedge clk); beat_chk("R11 page seq", 9'h100, 0);
      burst_stop = 1'b1;
      @(negedge clk);
      burst_stop = 1'b0;
      chk("R8 stop page2", 32'(col_vld), 0);

      // R8 stop while idle has no effect
      burst_stop = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 idle stop vld", 32'(col_vld), 0);
      burst_stop = 1'b0;
      go(4'h1, 9'h040);
      beat_chk("R8 after idle stop", 9'h040, 0);
      @(negedge clk); beat_chk("R8 after idle stop", 9'h041, 1);

      // R8 stop fixed burst early
      go(4'h3, 9'h000);
      @(negedge clk); beat_chk("R8 fixed", 9'h001, 0);
      burst_stop = 1'b1;
      @(negedge clk);
      burst_stop = 1'b0;
      chk("R8 stop fixed", 32'(col_vld), 0);

      // R9 restart mid-burst with new mode
      go(4'h3, 9'h010);
      @(negedge clk); beat_chk("R9 old", 9'h011, 0);
      burst_go = 1'b1; mode_img = 4'hA; go_col = 9'h0F5;
      @(negedge clk);
      burst_go = 1'b0;
      beat_chk("R9 restart", 9'h0F5, 0);
      @(negedge clk); beat_chk("R9 restart", 9'h0F4, 0);
      @(negedge clk); beat_chk("R9 restart", 9'h0F7, 0);
      @(negedge clk); beat_chk("R9 restart", 9'h0F6, 1);
      @(negedge clk); chk("R9 end", 32'(col_vld), 0);

      // R9 go beats stop on same edge
      go(4'h7, 9'h020);
      burst_go = 1'b1; burst_stop = 1'b1; mode_img = 4'h2; go_col = 9'h07E;
      @(negedge clk);
      burst_go = 1'b0; burst_stop = 1'b0;
      beat_chk("R9 go over stop", 9'h07E, 0);
      @(negedge clk); beat_chk("R9 go over stop", 9'h07F, 0);
      @(negedge clk); beat_chk("R9 go over stop", 9'h07C, 0);
      @(negedge clk); beat_chk("R9 go over stop", 9'h07D, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule